// File: doc/BRIEF.md
# Weighted Round-Robin Transmit Queue Scheduler

This block decides which of sixteen outbound message queues is served next. Software programs a circular sequence of sixteen slots through four 32-bit control words. Each slot names a queue and how many consecutive messages that queue may send before the scheduler moves to the following slot. A queue can appear in several slots, so both the service order and the share each queue gets are set by the sequence.

The scheduler looks at per-queue ready flags and grants one message at a time. It presents the chosen queue index with a valid strobe and holds it until the transmit side reports that the message either completed or must be retried. A retried message is attempted again on the same queue before the slot's count moves, so a retry never costs a queue its share. Slots with a zero count, or whose queue has nothing to send, are passed over in the same search cycle. The sequence wraps from the last slot to the first. Moving descriptors and transmitting packets are handled outside this block.

Top module: `wrr_queue_sched`

## Requirements
- R1: After reset, `sel_valid` is low, the slot pointer is at slot 0 and every slot count is zero, so no grant is made even when every queue is ready.
- R2: A write with `cfg_we` high stores `cfg_wdata` into control word `cfg_sel`. Slot k lives in word k/4 at bits [8*(k%4)+7 : 8*(k%4)], with the queue number in the low four bits of that byte and the message count in the high four bits. The write is used by the search from the next cycle.
- R3: When no message is outstanding and at least one slot is eligible, `sel_valid` is high in the next cycle and `sel_queue` holds the queue of the first eligible slot, scanning forward from the slot pointer.
- R4: A slot is eligible only if its count is nonzero and its queue's `q_ready` bit is 1. Ineligible slots are skipped within the same search.
- R5: A slot whose queue stays ready is granted exactly as many completed messages as its count, back to back, before the pointer moves to the next slot.
- R6: `msg_retry` while `sel_valid` is high keeps `sel_valid` high and `sel_queue` unchanged, and the message is not counted.
- R7: `msg_done` while `sel_valid` is high counts the message and drops `sel_valid` in the next cycle. The next grant can appear one cycle after that.
- R8: After the last slot (15), the search continues at slot 0.
- R9: While no slot is eligible, `sel_valid` stays low and the slot pointer and the slot's message tally hold.
- R10: `msg_done` and `msg_retry` are ignored while `sel_valid` is low.
- R11: If `msg_retry` and `msg_done` are both high in the same cycle, the retry wins and the message is not counted.
- R12: If the search lands on a slot other than the one at the pointer, that slot's message tally starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 2 | Index of the control word to write |
| cfg_wdata | input | 32 | Data holding four slot bytes |
| q_ready | input | 16 | Per-queue flag meaning the queue has a message to send |
| msg_done | input | 1 | The granted message completed |
| msg_retry | input | 1 | The granted message must be sent again |
| sel_valid | output | 1 | A grant is outstanding |
| sel_queue | output | 4 | Index of the granted queue |

## Verification
A grant is registered: `sel_valid` and `sel_queue` change one clock after the idle cycle in which the search finds an eligible slot. They fall one clock after the cycle that carries `msg_done`, and they stay unchanged after `msg_retry`. The bench drives its inputs one time unit after a rising edge. It reads the outputs one edge later, at the same offset, so each check samples exactly the cycle in which a result is due. Each message is completed in its own two-cycle step, which lets the full grant order, including skips, wraps and retries, be compared against a sequence worked out from the programmed slots.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

  // Scheduler state: waiting for an eligible slot, or holding a grant.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } wrr_state_e;

endpackage

// File: rtl/wrr_slot_regs.sv
module wrr_slot_regs #(
  parameter int unsigned N_REGS        = 4,
  parameter int unsigned REG_W         = 32,
  parameter int unsigned SLOTS_PER_REG = 4,
  parameter int unsigned Q_W           = 4,
  parameter int unsigned CNT_W         = 4,
  localparam int unsigned N_SLOTS      = N_REGS * SLOTS_PER_REG,
  localparam int unsigned SLOT_W       = Q_W + CNT_W,
  localparam int unsigned AW           = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_idx_i,
  input  logic [REG_W-1:0]         wr_data_i,
  output logic [N_SLOTS*Q_W-1:0]   slot_q_o,
  output logic [N_SLOTS*CNT_W-1:0] slot_cnt_o
);

  logic [REG_W-1:0] word_q [N_REGS];

  // One enabled register per control word.
  for (genvar r = 0; r < N_REGS; r++) begin : g_word
    logic word_en;
    assign word_en = wr_en_i && (wr_idx_i == AW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[r] <= '0;
      end else if (word_en) begin
        word_q[r] <= wr_data_i;
      end
    end
  end

  // Slot k sits in word k/SLOTS_PER_REG, queue field low, count field high.
  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    localparam int unsigned WI  = k / SLOTS_PER_REG;
    localparam int unsigned OFS = (k % SLOTS_PER_REG) * SLOT_W;
    assign slot_q_o[k*Q_W +: Q_W]       = word_q[WI][OFS +: Q_W];
    assign slot_cnt_o[k*CNT_W +: CNT_W] = word_q[WI][OFS+Q_W +: CNT_W];
  end

endmodule

// File: rtl/wrr_slot_search.sv
module wrr_slot_search #(
  parameter int unsigned N_SLOTS  = 16,
  parameter int unsigned N_QUEUES = 16,
  parameter int unsigned Q_W      = 4,
  parameter int unsigned CNT_W    = 4,
  localparam int unsigned S_W     = $clog2(N_SLOTS)
) (
  input  logic [S_W-1:0]           start_i,
  input  logic [N_SLOTS*Q_W-1:0]   slot_q_i,
  input  logic [N_SLOTS*CNT_W-1:0] slot_cnt_i,
  input  logic [N_QUEUES-1:0]      q_ready_i,
  output logic                     hit_o,
  output logic [S_W-1:0]           hit_slot_o
);

  logic [N_SLOTS-1:0] elig;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_elig
    assign elig[k] = (|slot_cnt_i[k*CNT_W +: CNT_W]) &&
                     q_ready_i[slot_q_i[k*Q_W +: Q_W]];
  end

  // Rotating priority: the lowest offset from start_i wins.
  always_comb begin
    hit_o      = 1'b0;
    hit_slot_o = start_i;
    for (int off = N_SLOTS - 1; off >= 0; off--) begin
      int pos;
      pos = int'(start_i) + off;
      if (pos >= int'(N_SLOTS)) pos = pos - int'(N_SLOTS);
      if (elig[pos]) begin
        hit_o      = 1'b1;
        hit_slot_o = S_W'(pos);
      end
    end
  end

endmodule

// File: rtl/wrr_sched_core.sv
module wrr_sched_core
  import wrr_pkg::*;
#(
  parameter int unsigned N_SLOTS = 16,
  parameter int unsigned Q_W     = 4,
  parameter int unsigned CNT_W   = 4,
  localparam int unsigned S_W    = $clog2(N_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic [S_W-1:0]   hit_slot_i,
  input  logic [Q_W-1:0]   hit_q_i,
  input  logic [CNT_W-1:0] hit_cnt_i,
  input  logic             done_i,
  input  logic             retry_i,
  output logic             busy_o,
  output logic [S_W-1:0]   ptr_o,
  output logic [Q_W-1:0]   cur_q_o
);

  wrr_state_e       state_q, state_d;
  logic [S_W-1:0]   ptr_q, ptr_d;
  logic [CNT_W-1:0] sent_q, sent_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [Q_W-1:0]   cur_q_q, cur_q_d;
  logic             upd;
  logic [CNT_W:0]   sent_inc;
  logic             slot_last;
  logic [S_W-1:0]   ptr_next;

  assign sent_inc  = {1'b0, sent_q} + 1'b1;
  assign slot_last = sent_inc >= {1'b0, cnt_q};
  assign ptr_next  = (ptr_q == S_W'(N_SLOTS - 1)) ? '0 : ptr_q + 1'b1;

  // Clock enable: a new grant, or a completion that is not a retry.
  assign upd = (state_q == ST_IDLE) ? hit_i : (done_i && !retry_i);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    sent_d  = sent_q;
    cnt_d   = cnt_q;
    cur_q_d = cur_q_q;
    if (state_q == ST_IDLE) begin
      state_d = ST_BUSY;
      ptr_d   = hit_slot_i;
      sent_d  = (hit_slot_i == ptr_q) ? sent_q : '0;
      cnt_d   = hit_cnt_i;
      cur_q_d = hit_q_i;
    end else begin
      state_d = ST_IDLE;
      if (slot_last) begin
        ptr_d  = ptr_next;
        sent_d = '0;
      end else begin
        sent_d = sent_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      sent_q  <= '0;
      cnt_q   <= '0;
      cur_q_q <= '0;
    end else if (upd) begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      sent_q  <= sent_d;
      cnt_q   <= cnt_d;
      cur_q_q <= cur_q_d;
    end
  end

  assign busy_o  = (state_q == ST_BUSY);
  assign ptr_o   = ptr_q;
  assign cur_q_o = cur_q_q;

  AST_RETRY_HOLDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && retry_i) |=> (busy_o && $stable(cur_q_o) && $stable(ptr_o))); // R6

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i && !retry_i) |=> !busy_o); // R7

  AST_IDLE_POINTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !hit_i) |=> (!busy_o && $stable(ptr_o))); // R9

  AST_IDLE_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !hit_i && (done_i || retry_i)) |=> $stable(sent_q)); // R10

endmodule

// File: rtl/wrr_queue_sched.sv
module wrr_queue_sched #(
  parameter int unsigned N_QUEUES      = 16,
  parameter int unsigned N_REGS        = 4,
  parameter int unsigned REG_W         = 32,
  parameter int unsigned SLOTS_PER_REG = 4,
  parameter int unsigned CNT_W         = 4,
  localparam int unsigned Q_W          = $clog2(N_QUEUES),
  localparam int unsigned N_SLOTS      = N_REGS * SLOTS_PER_REG,
  localparam int unsigned S_W          = $clog2(N_SLOTS),
  localparam int unsigned AW           = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_sel,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic [N_QUEUES-1:0] q_ready,
  input  logic                msg_done,
  input  logic                msg_retry,
  output logic                sel_valid,
  output logic [Q_W-1:0]      sel_queue
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [N_SLOTS*Q_W-1:0]   slot_q;
  logic [N_SLOTS*CNT_W-1:0] slot_cnt;
  logic                     hit;
  logic [S_W-1:0]           hit_slot;
  logic [S_W-1:0]           ptr;
  logic [Q_W-1:0]           hit_q;
  logic [CNT_W-1:0]         hit_cnt;

  wrr_slot_regs #(
    .N_REGS(N_REGS), .REG_W(REG_W), .SLOTS_PER_REG(SLOTS_PER_REG),
    .Q_W(Q_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en_i(cfg_we), .wr_idx_i(cfg_sel), .wr_data_i(cfg_wdata),
    .slot_q_o(slot_q), .slot_cnt_o(slot_cnt)
  );

  wrr_slot_search #(
    .N_SLOTS(N_SLOTS), .N_QUEUES(N_QUEUES), .Q_W(Q_W), .CNT_W(CNT_W)
  ) u_search (
    .start_i(ptr), .slot_q_i(slot_q), .slot_cnt_i(slot_cnt),
    .q_ready_i(q_ready), .hit_o(hit), .hit_slot_o(hit_slot)
  );

  assign hit_q   = slot_q[hit_slot*Q_W +: Q_W];
  assign hit_cnt = slot_cnt[hit_slot*CNT_W +: CNT_W];

  wrr_sched_core #(
    .N_SLOTS(N_SLOTS), .Q_W(Q_W), .CNT_W(CNT_W)
  ) u_core (
    .clk(clk), .rst_n(rst_sync_n),
    .hit_i(hit), .hit_slot_i(hit_slot), .hit_q_i(hit_q), .hit_cnt_i(hit_cnt),
    .done_i(msg_done), .retry_i(msg_retry),
    .busy_o(sel_valid), .ptr_o(ptr), .cur_q_o(sel_queue)
  );

  AST_GRANT_WAS_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sel_valid) |-> (|(($past(q_ready) >> sel_queue) & N_QUEUES'(1)))); // R3

endmodule

// File: tb/tb_wrr_queue_sched.sv
module tb_wrr_queue_sched;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ALL = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [15:0] q_ready;
  logic        msg_done;
  logic        msg_retry;
  logic        sel_valid;
  logic [3:0]  sel_queue;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrr_queue_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .q_ready(q_ready), .msg_done(msg_done),
    .msg_retry(msg_retry), .sel_valid(sel_valid), .sel_queue(sel_queue)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = 2'(idx); cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  // One grant completed by msg_done: valid one cycle after the search, low one cycle after done.
  task automatic serve(int expq, string req);
    tick();
    chk(req, "grant valid", int'(sel_valid), 1);
    chk(req, "granted queue", int'(sel_queue), expq);
    msg_done = 1'b1;
    tick();
    msg_done = 1'b0;
    chk("R7", "valid after done", int'(sel_valid), 0);
  endtask

  task automatic t_reset();
    q_ready = ALL;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R1", "valid with empty slots", int'(sel_valid), 0);
    end
    q_ready = '0;
  endtask

  // slot0 q3 x2, slot1 q5 x2, slot2 q7 x0, slot3 q9 x1, slot15 q12 x1
  task automatic t_sequence();
    wr(0, 32'h19_07_25_23);
    wr(3, 32'h1C_00_00_00);
    q_ready = ALL;
    serve(3, "R2");
    serve(3, "R5");
    serve(5, "R5");
    serve(5, "R5");
    serve(9, "R4");
    serve(12, "R3");
    serve(3, "R8");
  endtask

  task automatic t_retry();
    tick();
    chk("R6", "valid", int'(sel_valid), 1);
    chk("R6", "queue", int'(sel_queue), 3);
    msg_retry = 1'b1;
    tick();
    msg_retry = 1'b0;
    chk("R6", "valid after retry", int'(sel_valid), 1);
    chk("R6", "queue after retry", int'(sel_queue), 3);
    tick();
    chk("R6", "still held", int'(sel_valid), 1);
    msg_done = 1'b1;
    tick();
    msg_done = 1'b0;
    chk("R7", "valid after done", int'(sel_valid), 0);
    serve(5, "R6");
    serve(5, "R5");
  endtask

  task automatic t_skip_unready();
    q_ready = ALL & ~(16'h1 << 9);
    serve(12, "R4");
    serve(3, "R8");
  endtask

  task automatic t_idle_hold();
    q_ready = '0;
    tick();
    chk("R9", "valid none ready", int'(sel_valid), 0);
    msg_done = 1'b1;
    tick();
    msg_done = 1'b0;
    chk("R10", "done while idle", int'(sel_valid), 0);
    msg_retry = 1'b1;
    tick();
    msg_retry = 1'b0;
    tick();
    chk("R9", "valid still low", int'(sel_valid), 0);
    q_ready = ALL;
    serve(3, "R10");
    serve(5, "R9");
    serve(5, "R9");
  endtask

  task automatic t_clash();
    tick();
    chk("R11", "valid", int'(sel_valid), 1);
    chk("R11", "queue", int'(sel_queue), 9);
    msg_done = 1'b1; msg_retry = 1'b1;
    tick();
    msg_done = 1'b0; msg_retry = 1'b0;
    chk("R11", "valid after clash", int'(sel_valid), 1);
    chk("R11", "queue after clash", int'(sel_queue), 9);
    msg_done = 1'b1;
    tick();
    msg_done = 1'b0;
    chk("R7", "valid after done", int'(sel_valid), 0);
    serve(12, "R8");
  endtask

  task automatic t_midslot();
    serve(3, "R12");
    q_ready = ALL & ~(16'h1 << 3);
    serve(5, "R12");
    serve(5, "R12");
    serve(9, "R12");
    serve(12, "R12");
    q_ready = ALL;
    serve(3, "R12");
    serve(3, "R12");
    serve(5, "R12");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    q_ready = '0; msg_done = 1'b0; msg_retry = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "valid in reset", int'(sel_valid), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_sequence();
    t_retry();
    t_skip_unready();
    t_idle_hold();
    t_clash();
    t_midslot();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule